// File: doc/BRIEF.md
# Compressed Instruction Length and Mode Tracker

This block is the first stage of a two-stage instruction decoder for an instruction stream that mixes standard 32-bit instructions with 16-bit compressed ones. In every cycle it looks at the leading header bits of the instruction at the current fetch position. From those bits and a small mode state it reports three things: whether that instruction is 16 or 32 bits long, which mode it belongs to (standard, 10-bit compressed or 16-bit compressed), and the byte offset to the next instruction. When the instruction is accepted it moves the state on to the mode of the following instruction.

Two header bits of each compressed instruction carry the mode from one instruction to the next. Bit 0 is the most significant bit of the halfword. The "stay" bit is halfword bit 15 and the "excursion" bit is halfword bit 0. One transition is a one-shot excursion: exactly one standard instruction runs, and then the block drops back into 16-bit compressed mode by itself. Opcode decoding and the immediate sub-mode belong to the second stage, which cannot change a length or mode already reported here. A mode-override input, for example from trap entry, returns the tracker to standard mode.

Top module: `cinsn_len_tracker`

## Requirements
- R1: After reset the tracker is in standard state. An instruction without the escape tag then reports length 32 and mode 0 (standard).
- R2: The header fields are taken from the first halfword, which is `win_i[31:16]`. The excursion bit is `win_i[31]` (halfword bit 0), the stay bit is `win_i[16]` (halfword bit 15), and the escape tag is true when `win_i[31:27]` is all zero.
- R3: In standard state, an instruction with the escape tag reports length 16 and mode 1 (10-bit compressed). An instruction without the tag reports length 32 and mode 0, and the state stays standard.
- R4: After an accepted 10-bit compressed instruction, the next state is 16-bit compressed if its stay bit is 1, and standard if its stay bit is 0.
- R5: In 16-bit compressed state, every instruction reports length 16 and mode 2 (16-bit compressed). An accepted instruction with stay bit 1 keeps this state.
- R6: An accepted 16-bit compressed instruction with stay bit 0 and excursion bit 0 moves the tracker to standard state. With stay bit 0 and excursion bit 1 it moves the tracker to the one-shot state.
- R7: In the one-shot state the instruction reports length 32 and mode 0, even when it carries the escape tag. Accepting it returns the tracker to 16-bit compressed state.
- R8: `illegal_o` is 1 only when the tracker is in the one-shot state and the window carries the escape tag; otherwise it is 0.
- R9: The state advances only in a cycle with `win_valid_i && win_ready_i`. In any other cycle it holds, unless the override is active.
- R10: `next_off_o` is 2 for a 16-bit instruction and 4 for a 32-bit one.
- R11: `mode_rst_i` high at a clock edge puts the tracker in standard state for the next cycle. It takes priority over an accepted transition and does not depend on the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| win_i | input | 32 | Instruction window; the first halfword is in bits 31:16 |
| win_valid_i | input | 1 | The window holds an instruction |
| win_ready_i | input | 1 | The next stage accepts the instruction |
| mode_rst_i | input | 1 | Forces standard state at the next edge |
| len_o | output | 6 | Instruction length in bits (16 or 32) |
| mode_o | output | 2 | 0 standard, 1 10-bit compressed, 2 16-bit compressed |
| next_off_o | output | 3 | Byte offset to the next instruction |
| illegal_o | output | 1 | Escape tag seen inside the one-shot excursion |

## Verification
Two things can land on the same clock edge: the override from trap entry, and an accepted instruction whose header bits ask for a different mode. The bench drives both together in directed cases. In one, the override meets an accepted 16-bit instruction that would enter the one-shot state; in another, it meets an accepted one-shot instruction that would return to 16-bit mode. The random stream then raises the override on about one cycle in twenty, with a random handshake. In each such case the bench judges the result by what the next window reports: with the override, a tagged window must read back as 10-bit compressed, never as 16-bit or as a one-shot standard instruction.

// File: rtl/cinsn_pkg.sv
package cinsn_pkg;

    typedef enum logic [1:0] {
        MODE_STD = 2'd0,
        MODE_C10 = 2'd1,
        MODE_C16 = 2'd2
    } imode_e;

    typedef enum logic [1:0] {
        ST_STD  = 2'd0,
        ST_C16  = 2'd1,
        ST_ONCE = 2'd2
    } trk_state_e;

    typedef struct packed {
        logic xbit;
        logic sbit;
        logic tag;
    } hdr_t;

    typedef struct packed {
        trk_state_e st;
    } trk_regs_t;

endpackage

// File: rtl/cinsn_hdr_extract.sv
module cinsn_hdr_extract
    import cinsn_pkg::*;
#(
    parameter int WIN_W = 32,
    parameter int HW_W  = 16,
    parameter int TAG_W = 5,
    parameter logic [TAG_W-1:0] TAG_VAL = '0
) (
    input  logic [WIN_W-1:0] win_i,
    output hdr_t             hdr_o
);
    localparam int TOP = WIN_W - 1;
    localparam int SBIT_POS = WIN_W - HW_W;

    always_comb begin
        hdr_o.xbit = win_i[TOP];
        hdr_o.sbit = win_i[SBIT_POS];
        hdr_o.tag  = (win_i[TOP -: TAG_W] == TAG_VAL);
    end
endmodule

// File: rtl/cinsn_classify.sv
module cinsn_classify
    import cinsn_pkg::*;
(
    input  trk_state_e st_i,
    input  hdr_t       hdr_i,
    output imode_e     mode_o,
    output logic       long_o,
    output logic       illegal_o,
    output trk_state_e st_next_o
);
    always_comb begin
        mode_o    = MODE_STD;
        long_o    = 1'b1;
        illegal_o = 1'b0;
        st_next_o = ST_STD;
        unique case (st_i)
            ST_STD: begin
                if (hdr_i.tag) begin
                    mode_o    = MODE_C10;
                    long_o    = 1'b0;
                    st_next_o = hdr_i.sbit ? ST_C16 : ST_STD;
                end
            end
            ST_C16: begin
                mode_o = MODE_C16;
                long_o = 1'b0;
                if (hdr_i.sbit)      st_next_o = ST_C16;
                else if (hdr_i.xbit) st_next_o = ST_ONCE;
                else                 st_next_o = ST_STD;
            end
            ST_ONCE: begin
                illegal_o = hdr_i.tag;
                st_next_o = ST_C16;
            end
            default: st_next_o = ST_STD;
        endcase
    end
endmodule

// File: rtl/cinsn_len_tracker.sv
module cinsn_len_tracker
    import cinsn_pkg::*;
#(
    parameter int WIN_W = 32,
    parameter int HW_W  = 16,
    parameter int TAG_W = 5,
    localparam int LEN_W = $clog2(WIN_W + 1),
    localparam int OFF_W = $clog2(WIN_W / 8 + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIN_W-1:0] win_i,
    input  logic             win_valid_i,
    input  logic             win_ready_i,
    input  logic             mode_rst_i,
    output logic [LEN_W-1:0] len_o,
    output logic [1:0]       mode_o,
    output logic [OFF_W-1:0] next_off_o,
    output logic             illegal_o
);
    localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(HW_W);
    localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(WIN_W);
    localparam logic [OFF_W-1:0] OFF_SHORT = OFF_W'(HW_W / 8);
    localparam logic [OFF_W-1:0] OFF_LONG  = OFF_W'(WIN_W / 8);

    trk_regs_t  regs_d, regs_q;
    hdr_t       hdr;
    imode_e     cls_mode;
    logic       cls_long;
    logic       cls_ill;
    trk_state_e st_next;
    logic       accept;

    cinsn_hdr_extract #(
        .WIN_W(WIN_W), .HW_W(HW_W), .TAG_W(TAG_W)
    ) hdr_i (
        .win_i (win_i),
        .hdr_o (hdr)
    );

    cinsn_classify cls_i (
        .st_i      (regs_q.st),
        .hdr_i     (hdr),
        .mode_o    (cls_mode),
        .long_o    (cls_long),
        .illegal_o (cls_ill),
        .st_next_o (st_next)
    );

    assign accept = win_valid_i && win_ready_i;

    always_comb begin
        regs_d = regs_q;
        if (mode_rst_i)  regs_d.st = ST_STD;
        else if (accept) regs_d.st = st_next;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) regs_q <= '{st: ST_STD};
        else       regs_q <= regs_d;
    end

    assign len_o      = cls_long ? LEN_LONG : LEN_SHORT;
    assign next_off_o = cls_long ? OFF_LONG : OFF_SHORT;
    assign mode_o     = cls_mode;
    assign illegal_o  = cls_ill;

    a_r1_reset_std: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> regs_q.st == ST_STD);
    a_r11_override_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_rst_i |=> regs_q.st == ST_STD);
    a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (!accept && !mode_rst_i) |=> $stable(regs_q.st));
    a_r7_once_returns: assert property (@(posedge clk_i) disable iff (rst_i)
        (regs_q.st == ST_ONCE && accept && !mode_rst_i) |=> regs_q.st == ST_C16);
    a_r8_illegal_scope: assert property (@(posedge clk_i) disable iff (rst_i)
        illegal_o |-> (mode_o == MODE_STD && len_o == LEN_LONG && regs_q.st == ST_ONCE));
    a_r10_offset_match: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o != MODE_STD) |-> (next_off_o == OFF_SHORT && len_o == LEN_SHORT));
endmodule

// File: tb/cinsn_len_tracker_tb_top.sv
module cinsn_len_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] win;
    logic        vld, rdy, frc;
    logic [5:0]  len;
    logic [1:0]  mode;
    logic [2:0]  off;
    logic        ill;

    int checks = 0;
    int errors = 0;
    int mst = 0;   // model state: 0 standard, 1 16-bit, 2 one-shot
    bit done = 0;

    always #4 clk = ~clk;

    cinsn_len_tracker dut_i (
        .clk_i(clk), .rst_i(rst), .win_i(win), .win_valid_i(vld),
        .win_ready_i(rdy), .mode_rst_i(frc), .len_o(len), .mode_o(mode),
        .next_off_o(off), .illegal_o(ill)
    );

    function automatic bit tag_of(logic [31:0] w);
        return w[31:27] == 5'd0;
    endfunction

    function automatic int exp_mode(int s, logic [31:0] w);
        if (s == 1) return 2;
        if (s == 0 && tag_of(w)) return 1;
        return 0;
    endfunction

    function automatic int exp_next(int s, logic [31:0] w, bit a, bit f);
        if (f) return 0;
        if (!a) return s;
        case (s)
            0: return (tag_of(w) && w[16]) ? 1 : 0;
            1: return w[16] ? 1 : (w[31] ? 2 : 0);
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] mk(bit x, bit s, bit t);
        logic [31:0] w = $urandom;
        w[31] = x;
        if (t) w[31:27] = 5'd0;
        else if (w[31:27] == 5'd0) w[28] = 1'b1;
        w[16] = s;
        return w;
    endfunction

    task automatic chk(string rq, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic step(logic [31:0] w, bit v, bit r, bit f, string rq);
        int em;
        @(negedge clk);
        win = w; vld = v; rdy = r; frc = f;
        #2;
        em = exp_mode(mst, w);
        chk(rq, int'(mode), em, "mode");
        chk(rq, int'(len), (em == 0) ? 32 : 16, "len");
        chk("R10", int'(off), (em == 0) ? 4 : 2, "offset");
        chk("R8", int'(ill), (mst == 2 && tag_of(w)) ? 1 : 0, "illegal");
        mst = exp_next(mst, w, v && r, f);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; win = '0; vld = 0; rdy = 0; frc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        mst = 0;
        // R1 reset state, no tag -> standard
        step(mk(1, 0, 0), 1, 1, 0, "R1");
        // R2 R3 tag in standard -> 10-bit, stay bit 1 -> 16-bit (R4)
        step(mk(0, 1, 1), 1, 1, 0, "R3");
        // R5 16-bit with stay
        step(mk(1, 1, 0), 1, 1, 0, "R5");
        // R6 excursion: stay 0, x 1 -> one-shot
        step(mk(1, 0, 0), 1, 1, 0, "R6");
        // R7 one-shot with tag: standard, illegal
        step(mk(0, 0, 1), 1, 1, 0, "R7");
        // back in 16-bit
        step(mk(0, 0, 0), 1, 1, 0, "R7");
        // R6 N=0 -> standard; check tag now gives 10-bit with stay 0 -> standard (R4)
        step(mk(0, 0, 1), 1, 1, 0, "R4");
        step(mk(0, 0, 1), 1, 1, 0, "R4");
        // R9 not accepted: hold in standard after 10-bit with stay 1
        step(mk(0, 1, 1), 1, 0, 0, "R9");
        step(mk(0, 1, 1), 0, 1, 0, "R9");
        step(mk(0, 1, 1), 1, 1, 0, "R9");
        // now 16-bit; R11 override collides with accepted one-shot entry
        step(mk(1, 0, 0), 1, 1, 1, "R11");
        step(mk(0, 1, 1), 1, 1, 0, "R11");
        // now 16-bit; enter one-shot, override with accept in one-shot
        step(mk(1, 0, 0), 1, 1, 0, "R6");
        step(mk(1, 1, 0), 1, 1, 1, "R11");
        step(mk(0, 1, 1), 0, 0, 0, "R11");
        // R11 override without handshake
        step(mk(0, 1, 1), 1, 1, 0, "R11");
        step(mk(1, 1, 0), 0, 0, 1, "R11");
        step(mk(0, 0, 1), 0, 0, 0, "R11");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit t = ($urandom_range(0, 9) < 4);
            step(mk(t ? 1'b0 : 1'($urandom), 1'($urandom), t),
                 $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                 $urandom_range(0, 19) == 0,
                 (mst == 0) ? "R3" : (mst == 1) ? "R5" : "R7");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule